// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter with Full-Match Alarm

This block is the timekeeping core of a real-time clock. It receives a single-cycle enable at 32.768 kHz and divides it down to whole seconds. It keeps seconds, minutes, hours, day of month, month and a two-digit year (00 to 99, read as 2000 to 2099) as packed BCD bytes. The carry runs through the true month lengths, and February has 29 days in every year divisible by four. Hours always count in 24-hour form.

A set of six alarm bytes is compared against the time that the next second step will produce. The alarm event is raised only when all six fields agree, because no field can be marked as don't-care. Software reaches the time, alarm, control, status and interrupt-enable registers through a simple byte-wide write strobe and a combinational read port. Every register sits on a 4-byte stride.

A busy flag covers the tick period that ends in a second step. While it is set, writes to the time registers are dropped, so software must poll it before updating the time. Two sticky event bits, the alarm and the one-second step, are cleared by writing 1 to them. Each event is gated by its own enable onto one interrupt line.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset the time reads 00:00:00, day 0x01, month 0x01, year 0x00. All alarm bytes, control, status and interrupt-enable read 0x00, and irq_o is 0. The register slots are at byte offsets as follows:
  - time fields: seconds 0x00, minutes 0x04, hours 0x08, day 0x0C, month 0x10, year 0x14;
  - alarm fields: in the same field order from 0x18 to 0x2C;
  - control: 0x30;
  - status: 0x34;
  - interrupt-enable: 0x38.
  Any other offset reads 0x00.
- R2: While control bit 0 (run) is 1, the seconds field steps once on every TICKS_PER_SEC-th tick_en pulse. The step is visible after the clock edge that samples that pulse. While run is 0, tick_en has no effect and the tick count restarts from zero.
- R3: The BCD carries are as follows: seconds 0x59 to 0x00, minutes 0x59 to 0x00, hours 0x23 to 0x00, month 0x12 to 0x01, year 0x99 to 0x00. Each field carries into the next field only when it wraps.
- R4: The day wraps to 0x01 after day 0x31, 0x30, 0x29 or 0x28, as follows:
  - months 01, 03, 05, 07, 08, 10 and 12 wrap after 0x31;
  - months 04, 06, 09 and 11 wrap after 0x30;
  - February wraps after 0x29 in years divisible by four, including year 00;
  - February wraps after 0x28 in all other years.
- R5: Status bit 0 (busy) is 1 while run is 1 and TICKS_PER_SEC-1 pulses of the current second have been counted. Busy therefore rises after the pulse before the stepping one and falls after the step. A write to a time register while busy is set is ignored. Alarm and other register writes are never blocked.
- R6: Status bit 6 (alarm) is set by a second step whose new time equals all six alarm bytes. A mismatch in any single field, including year, leaves it clear.
- R7: Status bit 2 (second event) is set by every second step. Writing 1 to status bit 6 or bit 2 clears that bit, and writing 0 leaves it unchanged. Status bit 1 reads the run bit.
- R8: Interrupt-enable bit 2 gates the second event and bit 3 gates the alarm. irq_o equals (alarm AND bit 3) OR (second event AND bit 2). Other enable bits read 0.
- R9: Control bit 3 (12/24-hour select) and all control bits other than bit 0 read as 0 and have no effect, so hours keep counting 00 to 23.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Single-cycle 32.768 kHz tick enable |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register slot |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| irq_o | output | 1 | Interrupt request |

## Verification
Read data is combinational, so a register value is due in the same cycle its address is presented. A write is visible from the cycle after the edge that samples the strobe.

A second step becomes visible immediately after the edge that samples the TICKS_PER_SEC-th tick pulse. That edge updates the time fields, both status events and irq_o together. Busy is visible one edge earlier, after the edge of the preceding pulse.

The bench drives every tick and write for exactly one cycle from the falling edge. It advances its own model at that point. It samples reads and irq_o shortly after the following falling edge, so each result is read one settled cycle after the edge that produced it.

// File: rtl/rtc_core_pkg.sv
`timescale 1ns/1ps
package rtc_core_pkg;

   localparam int NUM_FIELDS   = 6;
   localparam int SLOT_TIME0   = 0;
   localparam int SLOT_ALARM0  = 6;
   localparam int SLOT_CTRL    = 12;
   localparam int SLOT_STATUS  = 13;
   localparam int SLOT_IRQEN   = 14;

   localparam int CTRL_RUN_BIT = 0;
   localparam int ST_BUSY_BIT  = 0;
   localparam int ST_RUN_BIT   = 1;
   localparam int ST_SEC_BIT   = 2;
   localparam int ST_ALARM_BIT = 6;
   localparam int IE_TIMER_BIT = 2;
   localparam int IE_ALARM_BIT = 3;

   // field index: 0 seconds, 1 minutes, 2 hours, 3 day, 4 month, 5 year
   typedef logic [7:0] bcd8_t;
   typedef logic [NUM_FIELDS-1:0][7:0] cal_t;

   function automatic bcd8_t bcd_inc(input bcd8_t v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // divisibility by four read directly from the two BCD digits
   function automatic logic bcd_leap(input bcd8_t y);
      if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
   endfunction

   function automatic bcd8_t bcd_month_end(input bcd8_t m, input bcd8_t y);
      case (m)
         8'h02:                      return bcd_leap(y) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

   function automatic bcd8_t field_limit(input int idx, input cal_t cur);
      case (idx)
         0, 1:    return 8'h59;
         2:       return 8'h23;
         3:       return bcd_month_end(cur[4], cur[5]);
         4:       return 8'h12;
         default: return 8'h99;
      endcase
   endfunction

   function automatic bcd8_t field_base(input int idx);
      return ((idx == 3) || (idx == 4)) ? 8'h01 : 8'h00;
   endfunction

endpackage

// File: rtl/rtc_tick_div.sv
`timescale 1ns/1ps
module rtc_tick_div #(
   parameter int TICKS_PER_SEC = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_en,
   input  logic run,
   output logic step,
   output logic busy
);
   localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
   localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

   logic [CW-1:0] pre_q;
   logic          at_last;

   assign at_last = (pre_q == LAST);
   assign busy    = run && at_last;
   assign step    = busy && tick_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pre_q <= '0;
      else if (!run)    pre_q <= '0;
      else if (tick_en) pre_q <= at_last ? '0 : pre_q + 1'b1;
   end
endmodule

// File: rtl/rtc_calendar.sv
`timescale 1ns/1ps
module rtc_calendar
   import rtc_core_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  step,
   input  logic [NUM_FIELDS-1:0] wr_en,
   input  bcd8_t                 wdata,
   output cal_t                  time_q,
   output cal_t                  time_nxt
);
   logic [NUM_FIELDS-1:0] carry;

   assign carry[0] = 1'b1;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_FIELDS; gi++) begin : g_fld
         bcd8_t fld_q;
         bcd8_t lim;
         logic  wrap;

         assign lim  = field_limit(gi, time_q);
         assign wrap = (fld_q >= lim);
         assign time_q[gi]   = fld_q;
         assign time_nxt[gi] = carry[gi] ? (wrap ? field_base(gi) : bcd_inc(fld_q))
                                         : fld_q;
         if (gi < NUM_FIELDS - 1) begin : g_carry
            assign carry[gi+1] = carry[gi] && wrap;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         fld_q <= field_base(gi);
            else if (step)      fld_q <= time_nxt[gi];
            else if (wr_en[gi]) fld_q <= wdata;
         end
      end
   endgenerate
endmodule

// File: rtl/rtc_alarm_bank.sv
`timescale 1ns/1ps
module rtc_alarm_bank
   import rtc_core_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_FIELDS-1:0] wr_en,
   input  bcd8_t                 wdata,
   input  cal_t                  time_nxt,
   output cal_t                  alarm_q,
   output logic                  match
);
   logic [NUM_FIELDS-1:0] eq;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_FIELDS; gi++) begin : g_alm
         bcd8_t alm_q;
         assign alarm_q[gi] = alm_q;
         assign eq[gi]      = (time_nxt[gi] == alm_q);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         alm_q <= '0;
            else if (wr_en[gi]) alm_q <= wdata;
         end
      end
   endgenerate

   assign match = &eq;
endmodule

// File: rtl/rtc_event_ctl.sv
`timescale 1ns/1ps
module rtc_event_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   input  logic match,
   input  logic clr_alarm,
   input  logic clr_sec,
   input  logic ie_wr,
   input  logic ie_timer_d,
   input  logic ie_alarm_d,
   output logic st_alarm,
   output logic st_sec,
   output logic ie_timer,
   output logic ie_alarm,
   output logic irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_alarm <= 1'b0;
         st_sec   <= 1'b0;
         ie_timer <= 1'b0;
         ie_alarm <= 1'b0;
      end else begin
         st_alarm <= (step && match) || (st_alarm && !clr_alarm);
         st_sec   <= step || (st_sec && !clr_sec);
         if (ie_wr) begin
            ie_timer <= ie_timer_d;
            ie_alarm <= ie_alarm_d;
         end
      end
   end

   assign irq = (st_alarm && ie_alarm) || (st_sec && ie_timer);
endmodule

// File: rtl/rtc_bcd_core.sv
`timescale 1ns/1ps
module rtc_bcd_core
   import rtc_core_pkg::*;
#(
   parameter int TICKS_PER_SEC = 32768,
   parameter int ADDR_W        = 8,
   parameter int DATA_W        = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o
);
   localparam int SLOT_W = ADDR_W - 2;

   generate
      if (TICKS_PER_SEC < 2) begin : g_bad_ticks
         $error("rtc_bcd_core: TICKS_PER_SEC must be at least 2");
      end
      if (DATA_W != 8) begin : g_bad_data
         $error("rtc_bcd_core: DATA_W must be 8 for BCD byte registers");
      end
      if (ADDR_W < 6) begin : g_bad_addr
         $error("rtc_bcd_core: ADDR_W too small for the register slots");
      end
   endgenerate

   logic [SLOT_W-1:0]     slot;
   logic                  aligned;
   logic                  step, busy, run_q;
   cal_t                  time_q, time_nxt, alarm_q;
   logic                  match;
   logic [NUM_FIELDS-1:0] time_wr, alarm_wr;
   logic                  ctrl_wr, st_wr, ie_wr;
   logic                  st_alarm, st_sec, ie_timer, ie_alarm;
   bcd8_t                 wbyte;

   assign slot    = bus_addr[ADDR_W-1:2];
   assign aligned = (bus_addr[1:0] == 2'b00);
   assign wbyte   = bus_wdata[7:0];

   genvar gi;
   generate
      for (gi = 0; gi < NUM_FIELDS; gi++) begin : g_dec
         assign time_wr[gi]  = bus_wr && aligned && !busy &&
                               (slot == SLOT_W'(SLOT_TIME0 + gi));
         assign alarm_wr[gi] = bus_wr && aligned &&
                               (slot == SLOT_W'(SLOT_ALARM0 + gi));
      end
   endgenerate

   assign ctrl_wr = bus_wr && aligned && (slot == SLOT_W'(SLOT_CTRL));
   assign st_wr   = bus_wr && aligned && (slot == SLOT_W'(SLOT_STATUS));
   assign ie_wr   = bus_wr && aligned && (slot == SLOT_W'(SLOT_IRQEN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       run_q <= 1'b0;
      else if (ctrl_wr) run_q <= wbyte[CTRL_RUN_BIT];
   end

   rtc_tick_div #(.TICKS_PER_SEC(TICKS_PER_SEC)) i_div (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run(run_q),
      .step(step), .busy(busy)
   );

   rtc_calendar i_cal (
      .clk(clk), .rst_n(rst_n), .step(step), .wr_en(time_wr),
      .wdata(wbyte), .time_q(time_q), .time_nxt(time_nxt)
   );

   rtc_alarm_bank i_alm (
      .clk(clk), .rst_n(rst_n), .wr_en(alarm_wr), .wdata(wbyte),
      .time_nxt(time_nxt), .alarm_q(alarm_q), .match(match)
   );

   rtc_event_ctl i_evt (
      .clk(clk), .rst_n(rst_n), .step(step), .match(match),
      .clr_alarm(st_wr && wbyte[ST_ALARM_BIT]),
      .clr_sec(st_wr && wbyte[ST_SEC_BIT]),
      .ie_wr(ie_wr), .ie_timer_d(wbyte[IE_TIMER_BIT]),
      .ie_alarm_d(wbyte[IE_ALARM_BIT]),
      .st_alarm(st_alarm), .st_sec(st_sec),
      .ie_timer(ie_timer), .ie_alarm(ie_alarm), .irq(irq_o)
   );

   always_comb begin
      bus_rdata = '0;
      if (aligned) begin
         for (int i = 0; i < NUM_FIELDS; i++) begin
            if (slot == SLOT_W'(SLOT_TIME0 + i))  bus_rdata = time_q[i];
            if (slot == SLOT_W'(SLOT_ALARM0 + i)) bus_rdata = alarm_q[i];
         end
         if (slot == SLOT_W'(SLOT_CTRL))
            bus_rdata[CTRL_RUN_BIT] = run_q;
         if (slot == SLOT_W'(SLOT_STATUS)) begin
            bus_rdata[ST_BUSY_BIT]  = busy;
            bus_rdata[ST_RUN_BIT]   = run_q;
            bus_rdata[ST_SEC_BIT]   = st_sec;
            bus_rdata[ST_ALARM_BIT] = st_alarm;
         end
         if (slot == SLOT_W'(SLOT_IRQEN)) begin
            bus_rdata[IE_TIMER_BIT] = ie_timer;
            bus_rdata[IE_ALARM_BIT] = ie_alarm;
         end
      end
   end
endmodule

// File: rtl/rtc_bcd_core_chk.sv
`timescale 1ns/1ps
module rtc_bcd_core_chk #(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_en,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              step,
   input logic              busy,
   input logic              run_q,
   input logic [7:0]        sec_q,
   input logic              st_alarm,
   input logic              st_sec,
   input logic              irq_o
);
   // R2: a second step only happens while running
   a_r2_step_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> run_q);

   // R2: seconds change only through a step or a write to its slot
   a_r2_sec_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !(bus_wr && bus_addr == '0)) |=> $stable(sec_q));

   // R5: a seconds write while busy without a tick is dropped
   a_r5_busy_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && bus_wr && bus_addr == '0 && !tick_en) |=> $stable(sec_q));

   // R7: each step leaves the second event set
   a_r7_sec_event_set: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> st_sec);

   // R6: the alarm event rises only out of a step
   a_r6_alarm_from_step: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_alarm) |-> $past(step));

   // R8: the interrupt rises only after a step or a register write
   a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> ($past(step) || $past(bus_wr)));
endmodule

bind rtc_bcd_core rtc_bcd_core_chk #(.ADDR_W(ADDR_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .step(step), .busy(busy), .run_q(run_q),
   .sec_q(time_q[0]), .st_alarm(st_alarm), .st_sec(st_sec), .irq_o(irq_o)
);

// File: tb/test_rtc_bcd_core.sv
`timescale 1ns/1ps
module test_rtc_bcd_core;
   localparam int N = 4;
   typedef int cal_m_t [6];

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_addr = 8'h00;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       irq_o;

   always #2 clk = ~clk;

   rtc_bcd_core #(.TICKS_PER_SEC(N), .ADDR_W(8), .DATA_W(8)) i_rtc_bcd_core (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_o(irq_o)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   cal_m_t m_t, m_a;
   int run_m, pre_m, al_m, se_m, ie_m;

   function automatic int b2i(int b); return (b >> 4) * 10 + (b & 15); endfunction
   function automatic int i2b(int v); return ((v / 10) << 4) | (v % 10); endfunction
   function automatic int dim(int mo, int y);
      if (mo == 2) return (y % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   function automatic cal_m_t adv_f(cal_m_t t);
      cal_m_t r;
      int s, mi, h, d, mo, y;
      s = b2i(t[0]) + 1; mi = b2i(t[1]); h = b2i(t[2]);
      d = b2i(t[3]); mo = b2i(t[4]); y = b2i(t[5]);
      if (s == 60) begin s = 0; mi++; end
      if (mi == 60) begin mi = 0; h++; end
      if (h == 24) begin h = 0; d++; end
      if (d > dim(mo, y)) begin d = 1; mo++; end
      if (mo == 13) begin mo = 1; y++; end
      if (y == 100) y = 0;
      r[0] = i2b(s); r[1] = i2b(mi); r[2] = i2b(h);
      r[3] = i2b(d); r[4] = i2b(mo); r[5] = i2b(y);
      return r;
   endfunction

   function automatic int busy_m();
      return (run_m != 0 && pre_m == N - 1) ? 1 : 0;
   endfunction

   function automatic int exp_read(int addr);
      int idx;
      if ((addr & 3) != 0) return 0;
      idx = addr >> 2;
      if (idx < 6) return m_t[idx];
      if (idx < 12) return m_a[idx - 6];
      if (idx == 12) return run_m;
      if (idx == 13) return (al_m << 6) | (se_m << 2) | (run_m << 1) | busy_m();
      if (idx == 14) return ie_m;
      return 0;
   endfunction

   function automatic int exp_irq();
      return ((al_m != 0 && ie_m[3]) || (se_m != 0 && ie_m[2])) ? 1 : 0;
   endfunction

   task automatic check(string tag, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
      end
   endtask

   task automatic read_reg(int addr, output int val);
      bus_addr = addr[7:0];
      #1;
      val = int'(bus_rdata);
   endtask

   task automatic check_reg(string tag, int addr);
      int v;
      read_reg(addr, v);
      check(tag, $sformatf("reg 0x%02h", addr), v, exp_read(addr));
   endtask

   task automatic check_const(string tag, int addr, int exp);
      int v;
      read_reg(addr, v);
      check(tag, $sformatf("reg 0x%02h", addr), v, exp);
   endtask

   task automatic check_irq(string tag);
      check(tag, "irq_o", int'(irq_o), exp_irq());
   endtask

   task automatic bus_write(int addr, int data);
      int idx;
      idx = addr >> 2;
      if (idx < 6) begin
         if (busy_m() == 0) m_t[idx] = data;
      end else if (idx < 12) m_a[idx - 6] = data;
      else if (idx == 12) begin
         run_m = data & 1;
         if (run_m == 0) pre_m = 0;
      end else if (idx == 13) begin
         if (data[6]) al_m = 0;
         if (data[2]) se_m = 0;
      end else if (idx == 14) ie_m = data & 8'h0C;
      @(negedge clk);
      bus_addr = addr[7:0]; bus_wdata = data[7:0]; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic do_tick();
      if (run_m != 0) begin
         if (pre_m == N - 1) begin
            pre_m = 0;
            m_t = adv_f(m_t);
            se_m = 1;
            if (m_t == m_a) al_m = 1;
         end else pre_m++;
      end
      @(negedge clk);
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
   endtask

   task automatic set_time(int y, int mo, int d, int h, int mi, int s);
      bus_write(8'h00, s); bus_write(8'h04, mi); bus_write(8'h08, h);
      bus_write(8'h0C, d); bus_write(8'h10, mo); bus_write(8'h14, y);
   endtask

   task automatic day_roll(string tag, int y, int mo, int d, int exp_d, int exp_mo);
      bus_write(8'h30, 0);
      set_time(y, mo, d, 8'h23, 8'h59, 8'h59);
      bus_write(8'h30, 1);
      for (int k = 0; k < N; k++) do_tick();
      check_const(tag, 8'h0C, exp_d);
      check_const(tag, 8'h10, exp_mo);
      check_const(tag, 8'h08, 8'h00);
   endtask

   initial begin
      #800000;
      if (!done) begin
         n_fail++;
         $display("FAIL R1 watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int v, op, a;
      cal_m_t nx;
      void'($urandom(32'h5EED_0042));
      for (int i = 0; i < 6; i++) begin m_t[i] = 0; m_a[i] = 0; end
      m_t[3] = 1; m_t[4] = 1;
      run_m = 0; pre_m = 0; al_m = 0; se_m = 0; ie_m = 0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int ad = 0; ad < 64; ad += 4) check_reg("R1", ad);
      check_const("R1", 8'h0C, 8'h01);
      check_const("R1", 8'h34, 8'h00);
      check_irq("R1");

      // full wrap with alarm, 12/24 bit ignored
      set_time(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h58);
      for (int i = 0; i < 6; i++) bus_write(8'h18 + 4 * i, (i == 3 || i == 4) ? 1 : 0);
      bus_write(8'h38, 8'h08);
      bus_write(8'h30, 8'h09);
      check_const("R9", 8'h30, 8'h01);
      for (int k = 0; k < N - 1; k++) do_tick();
      check_const("R5", 8'h34, 8'h03);
      bus_write(8'h00, 8'h10);
      check_const("R5", 8'h00, 8'h58);
      do_tick();
      check_const("R2", 8'h00, 8'h59);
      check_const("R7", 8'h34, 8'h06);
      check_irq("R8");
      for (int k = 0; k < N; k++) do_tick();
      check_const("R3", 8'h00, 8'h00);
      check_const("R3", 8'h04, 8'h00);
      check_const("R9", 8'h08, 8'h00);
      check_const("R3", 8'h0C, 8'h01);
      check_const("R3", 8'h10, 8'h01);
      check_const("R3", 8'h14, 8'h00);
      check_const("R6", 8'h34, 8'h46);
      check("R8", "irq_o alarm", int'(irq_o), 1);

      // W1C behaviour
      bus_write(8'h34, 8'h00);
      check_const("R7", 8'h34, 8'h46);
      bus_write(8'h34, 8'h40);
      check_const("R7", 8'h34, 8'h06);
      check("R8", "irq_o after clear", int'(irq_o), 0);
      bus_write(8'h38, 8'hFF);
      check_const("R8", 8'h38, 8'h0C);
      check("R8", "irq_o timer", int'(irq_o), 1);
      bus_write(8'h34, 8'h04);
      check_const("R7", 8'h34, 8'h02);
      bus_write(8'h38, 8'h00);

      // month lengths and leap years
      day_roll("R4", 8'h24, 8'h02, 8'h28, 8'h29, 8'h02);
      day_roll("R4", 8'h24, 8'h02, 8'h29, 8'h01, 8'h03);
      day_roll("R4", 8'h23, 8'h02, 8'h28, 8'h01, 8'h03);
      day_roll("R4", 8'h00, 8'h02, 8'h28, 8'h29, 8'h02);
      day_roll("R4", 8'h30, 8'h04, 8'h30, 8'h01, 8'h05);
      day_roll("R4", 8'h30, 8'h01, 8'h31, 8'h01, 8'h02);
      day_roll("R4", 8'h30, 8'h11, 8'h30, 8'h01, 8'h12);
      check_const("R3", 8'h00, 8'h00);

      // single-field mismatch: year differs
      bus_write(8'h34, 8'h44);
      nx = adv_f(m_t);
      for (int i = 0; i < 6; i++) bus_write(8'h18 + 4 * i, (i == 5) ? (nx[5] ^ 8'h01) : nx[i]);
      for (int k = 0; k < N; k++) do_tick();
      check_const("R6", 8'h34, 8'h06);

      // stopped clock ignores ticks
      bus_write(8'h30, 0);
      read_reg(8'h00, v);
      for (int k = 0; k < 3 * N; k++) do_tick();
      check_const("R2", 8'h00, v);
      check_const("R7", 8'h34, 8'h04);
      bus_write(8'h30, 1);

      // constrained random
      for (int it = 0; it < 4000; it++) begin
         op = int'($urandom % 16);
         if (op < 9) do_tick();
         else if (op == 9) begin
            a = int'($urandom % 6);
            case (a)
               0, 1: v = i2b(int'($urandom % 60));
               2:    v = i2b(int'($urandom % 24));
               3:    v = i2b(1 + int'($urandom % 28));
               4:    v = i2b(1 + int'($urandom % 12));
               default: v = i2b(int'($urandom % 100));
            endcase
            bus_write(4 * a, v);
         end else if (op == 10) begin
            nx = adv_f(m_t);
            for (int i = 0; i < 6; i++) bus_write(8'h18 + 4 * i, nx[i]);
         end else if (op == 11) bus_write(8'h34, int'($urandom % 256));
         else if (op == 12) bus_write(8'h38, int'($urandom % 256));
         else if (op == 13) bus_write(8'h30, ($urandom % 10 == 0) ? 0 : int'($urandom % 256) | 1);
         else begin
            a = int'($urandom % 16);
            if (a < 6) check_reg("R3", 4 * a);
            else if (a < 12) check_reg("R6", 4 * a);
            else if (a == 12) check_reg("R9", 4 * a);
            else if (a == 13) check_reg("R7", 4 * a);
            else check_reg("R8", 4 * a);
         end
         if (it % 8 == 0) check_irq("R8");
      end
      for (int ad = 0; ad < 60; ad += 4) check_reg("R5", ad);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end
endmodule